// File: doc/BRIEF.md
# Timeslot Power Sequencing Controller

This block is the main power-state machine for a set of switched supplies. It drives one enable line per controlled output: regulators, a clock output and external power-enable pins. It moves between three stable states: OFF, ON (active) and SLEEP. Each output carries a 3-bit field that places it in one of five timeslots, T1 to T5. When the machine powers up, it walks the slots in ascending order and raises each slot's enables. When it powers down, it walks the slots in descending order and drops them.

Every slot lasts a fixed number of clock ticks. A slot stays open for longer while any output raised in it has not yet reported startup. Going down to OFF, into SLEEP, or waking from SLEEP waits out a programmable delay first. Powering up from OFF starts at once. An OFF request that arrives during SLEEP skips the slots entirely. A mask selects which outputs SLEEP turns off, and WAKE brings back those same outputs.

The current state appears as a 5-bit code. A one-cycle pulse on a per-target line marks each completed arrival in ON, OFF or SLEEP.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After reset the state is OFF: all enables are low, `state_code` is 00000 and no interrupt line is high.
- R2: From OFF, `ev_on` raises the enables of slot T1 on the clock edge after the edge that samples the event, with no delay. Later slots are then raised in ascending order. Field value 0..4 selects T1..T5, and values 5..7 count as T5. Enables only rise during a power-up walk, and in ON every enable is high.
- R3: Each slot lasts at least `SLOT_TICKS` cycles, so the enables of slot k+1 appear `SLOT_TICKS` cycles after those of slot k.
- R4: During a power-up walk, the current slot does not end while any output it enabled has its `started` bit low.
- R5: In ON, `ev_off` holds every enable unchanged for `pre_delay`+1 cycles after the sampling edge. The outputs are then cleared slot by slot from T5 down to T1, after which the state is OFF.
- R6: In ON, `ev_sleep` waits out the same delay and then clears, from T5 down to T1, only the outputs whose `sleep_mask` bit is 1. In SLEEP, `ev_wake` waits out the delay and then raises those outputs again from T1 up to T5.
- R7: In SLEEP, `ev_off` clears every enable, sets `state_code` to OFF and pulses `irq_off`, all on the next edge, with no slot walk.
- R8: `state_code` reads 00000 in OFF, 11111 in ON and 11100 in SLEEP. 01011 is reserved for a programming state and is never produced. Delays and walks show other codes.
- R9: Finishing a walk into ON (including a wake), OFF or SLEEP pulses `irq_on`, `irq_off` or `irq_sleep` for one cycle. At most one of these lines is high at a time.
- R10: Events that arrive during a delay or a walk are held. They are acted on once the machine settles. A held OFF wins over a held SLEEP or WAKE.
- R11: Events that do not apply to the current stable state (for example ON or WAKE while ON) are dropped and change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_on | input | 1 | Power-up request pulse |
| ev_off | input | 1 | Power-down request pulse |
| ev_sleep | input | 1 | Sleep request pulse |
| ev_wake | input | 1 | Wake request pulse |
| slot_cfg | input | 3*N_OUT | 3-bit slot field per output, output i at bits 3i+2..3i |
| sleep_mask | input | N_OUT | 1 = output is turned off in SLEEP |
| pre_delay | input | DLY_W | Delay in cycles before OFF, SLEEP and WAKE walks |
| started | input | N_OUT | Startup-complete status per output |
| en | output | N_OUT | Enable per output |
| state_code | output | 5 | Current state code |
| irq_on | output | 1 | Pulse on arrival in ON |
| irq_off | output | 1 | Pulse on arrival in OFF |
| irq_sleep | output | 1 | Pulse on arrival in SLEEP |

## Verification
The assertions check, on every cycle, the properties that hold at each step:
- Enables never fall during a power-up walk.
- OFF implies all enables are low, and ON implies all are high.
- Enables are frozen during the pre-transition delay.
- A waiting slot does not advance.
- A sleep-time OFF lands on the very next edge.
- The interrupt lines pulse singly.

The bench scenarios show the rest:
- The order of enable patterns for each kind of walk, against a scoreboard of expected patterns.
- The exact cycle of the first change and the slot spacing.
- The effect of the mask.
- Held events that take effect after a walk, with OFF winning.
- Inapplicable events that leave the outputs untouched.

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl #(
  parameter int N_OUT      = 6,
  parameter int SLOT_TICKS = 100000,
  parameter int DLY_W      = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ev_on,
  input  logic               ev_off,
  input  logic               ev_sleep,
  input  logic               ev_wake,
  input  logic [3*N_OUT-1:0] slot_cfg,
  input  logic [N_OUT-1:0]   sleep_mask,
  input  logic [DLY_W-1:0]   pre_delay,
  input  logic [N_OUT-1:0]   started,
  output logic [N_OUT-1:0]   en,
  output logic [4:0]         state_code,
  output logic               irq_on,
  output logic               irq_off,
  output logic               irq_sleep
);
  localparam int TW = (SLOT_TICKS > 1) ? $clog2(SLOT_TICKS) : 1;
  localparam logic [TW-1:0] TLAST = TW'(SLOT_TICKS - 1);
  localparam logic [2:0] TOP_SLOT = 3'd4;
  localparam logic [4:0] C_OFF = 5'b00000, C_ON = 5'b11111, C_SLP = 5'b11100;
  localparam logic [4:0] C_PROG = 5'b01011, C_DLY = 5'b00101;
  localparam logic [4:0] C_UP = 5'b00110, C_DN = 5'b01001;

  typedef enum logic [2:0] {P_OFF, P_ON, P_SLP, P_DLY, P_SEQ} phase_t;
  typedef enum logic [1:0] {OP_ON, OP_OFF, OP_SLP, OP_WAKE} op_t;

  phase_t            phase;
  op_t               op;
  logic [2:0]        cur;
  logic [TW-1:0]     tick;
  logic [DLY_W-1:0]  dcnt;
  logic              p_on, p_off, p_slp, p_wake;
  logic [N_OUT-1:0]  grp, opset;

  wire up        = (op == OP_ON) || (op == OP_WAKE);
  wire e_on      = p_on | ev_on;
  wire e_off     = p_off | ev_off;
  wire e_slp     = p_slp | ev_sleep;
  wire e_wake    = p_wake | ev_wake;
  wire waiting   = up && |(grp & ~started);
  wire slot_done = (tick == TLAST) && !waiting;
  wire last      = up ? (cur == TOP_SLOT) : (cur == 3'd0);

  assign opset = (op == OP_SLP || op == OP_WAKE) ? sleep_mask : '1;

  for (genvar i = 0; i < N_OUT; i++) begin : g_out
    logic [2:0] f;
    assign f      = slot_cfg[3*i +: 3];
    assign grp[i] = opset[i] && (((f > TOP_SLOT) ? TOP_SLOT : f) == cur);
  end

  always_comb begin
    case (phase)
      P_OFF:   state_code = C_OFF;
      P_ON:    state_code = C_ON;
      P_SLP:   state_code = C_SLP;
      P_DLY:   state_code = C_DLY;
      default: state_code = up ? C_UP : C_DN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= P_OFF; op <= OP_ON; cur <= '0; tick <= '0; dcnt <= '0; en <= '0;
      {p_on, p_off, p_slp, p_wake} <= '0;
      {irq_on, irq_off, irq_sleep} <= '0;
    end else begin
      {irq_on, irq_off, irq_sleep} <= '0;
      case (phase)
        P_OFF, P_ON, P_SLP: begin
          {p_on, p_off, p_slp, p_wake} <= '0;
          if (phase == P_OFF && e_on) begin
            phase <= P_SEQ; op <= OP_ON; cur <= '0; tick <= '0;
          end else if (phase == P_ON && (e_off || e_slp)) begin
            phase <= P_DLY; op <= e_off ? OP_OFF : OP_SLP; dcnt <= pre_delay;
          end else if (phase == P_SLP && e_off) begin
            phase <= P_OFF; en <= '0; irq_off <= 1'b1;
          end else if (phase == P_SLP && e_wake) begin
            phase <= P_DLY; op <= OP_WAKE; dcnt <= pre_delay;
          end
        end
        P_DLY: begin
          {p_on, p_off, p_slp, p_wake} <= {e_on, e_off, e_slp, e_wake};
          if (dcnt == '0) begin
            phase <= P_SEQ; cur <= up ? 3'd0 : TOP_SLOT; tick <= '0;
          end else dcnt <= dcnt - DLY_W'(1);
        end
        default: begin
          {p_on, p_off, p_slp, p_wake} <= {e_on, e_off, e_slp, e_wake};
          en <= up ? (en | grp) : (en & ~grp);
          if (slot_done) begin
            if (last) begin
              case (op)
                OP_OFF:  begin phase <= P_OFF; irq_off   <= 1'b1; end
                OP_SLP:  begin phase <= P_SLP; irq_sleep <= 1'b1; end
                default: begin phase <= P_ON;  irq_on    <= 1'b1; end
              endcase
            end else begin
              cur  <= up ? cur + 3'd1 : cur - 3'd1;
              tick <= '0;
            end
          end else if (tick != TLAST) tick <= tick + TW'(1);
        end
      endcase
    end
  end

  a_r1_off_dark: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == C_OFF) |-> (en == '0));
  a_r2_on_full: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == C_ON) |-> (en == '1));
  a_r2_ramp_monotone: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == P_SEQ && up) |=> ((en & $past(en)) == $past(en)));
  a_r4_stretch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == P_SEQ && waiting) |=> (phase == P_SEQ && $stable(cur)));
  a_r5_delay_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == P_DLY) |=> $stable(en));
  a_r7_direct_off: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == P_SLP && ev_off) |=> (state_code == C_OFF && en == '0 && irq_off));
  a_r8_no_prog: assert property (@(posedge clk) disable iff (!rst_n)
    state_code != C_PROG);
  a_r9_single_irq: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_on, irq_off, irq_sleep}));
  a_r9_on_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq_on |=> !irq_on);
endmodule

// File: tb/tb_pwr_seq_ctrl.sv
module tb_pwr_seq_ctrl;
  localparam int N = 6, T = 8, DW = 4;
  logic clk = 0, rst_n = 0;
  logic ev_on = 0, ev_off = 0, ev_sleep = 0, ev_wake = 0;
  logic [3*N-1:0] slot_cfg = {3'd6, 3'd4, 3'd3, 3'd2, 3'd1, 3'd0};
  logic [N-1:0] sleep_mask = 6'b100110, hold_low = '0, started, en;
  logic [DW-1:0] pre_delay = 4'd3;
  logic [4:0] state_code;
  logic irq_on, irq_off, irq_sleep;
  int checks = 0, errors = 0, cyc = 0;
  logic [6:0] q[$];
  logic [N-1:0] prev_en = '0;

  assign started = en & ~hold_low;
  always #10 clk = ~clk;

  pwr_seq_ctrl #(.N_OUT(N), .SLOT_TICKS(T), .DLY_W(DW)) dut (
    .clk, .rst_n, .ev_on, .ev_off, .ev_sleep, .ev_wake, .slot_cfg, .sleep_mask,
    .pre_delay, .started, .en, .state_code, .irq_on, .irq_off, .irq_sleep);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push_en(logic [N-1:0] v);
    q.push_back({1'b0, v});
  endtask
  task automatic push_irq(logic [2:0] v);
    q.push_back({1'b1, 3'b0, v});
  endtask

  task automatic pulse(logic on, logic off, logic slp, logic wk);
    {ev_on, ev_off, ev_sleep, ev_wake} = {on, off, slp, wk};
    @(posedge clk); @(negedge clk);
    {ev_on, ev_off, ev_sleep, ev_wake} = '0;
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic push_on_walk();
    push_en(6'h01); push_en(6'h03); push_en(6'h07); push_en(6'h0F); push_en(6'h3F);
    push_irq(3'b100);
  endtask
  task automatic push_off_walk();
    push_en(6'h0F); push_en(6'h07); push_en(6'h03); push_en(6'h01); push_en(6'h00);
    push_irq(3'b010);
  endtask
  task automatic push_sleep_walk();
    push_en(6'h1F); push_en(6'h1B); push_en(6'h19); push_irq(3'b001);
  endtask

  always @(negedge clk) if (rst_n) begin
    if (en !== prev_en) begin
      if (q.size() == 0) check("R11 unexpected enable change", {26'b0, en}, {26'b0, prev_en});
      else check("R2/R5/R6 enable order", {25'b0, 1'b0, en}, {25'b0, q.pop_front()});
      prev_en = en;
    end
    if (irq_on | irq_off | irq_sleep) begin
      if (q.size() == 0) check("R11 unexpected interrupt", {29'b0, irq_on, irq_off, irq_sleep}, 0);
      else check("R9 interrupt", {25'b0, 1'b1, 3'b0, irq_on, irq_off, irq_sleep},
                 {25'b0, q.pop_front()});
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 60000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected<60000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 en", {26'b0, en}, 0);
    check("R1 code", {27'b0, state_code}, 0);
    check("R1 irq", {29'b0, irq_on, irq_off, irq_sleep}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check("R1 code after release", {27'b0, state_code}, 0);

    push_on_walk();
    pulse(1, 0, 0, 0);
    check("R2 no change at sampling edge", {26'b0, en}, 0);
    @(posedge clk); @(negedge clk);
    check("R2 T1 next edge", {26'b0, en}, 6'h01);
    repeat (T - 1) begin @(posedge clk); @(negedge clk); end
    check("R3 T2 not early", {26'b0, en}, 6'h01);
    @(posedge clk); @(negedge clk);
    check("R3 T2 after slot", {26'b0, en}, 6'h03);
    drain();
    check("R8 ON code", {27'b0, state_code}, 5'b11111);

    push_off_walk();
    pulse(0, 1, 0, 0);
    for (int k = 1; k <= 4; k++) begin
      @(posedge clk); @(negedge clk);
      check("R5 held during delay", {26'b0, en}, 6'h3F);
    end
    @(posedge clk); @(negedge clk);
    check("R5 T5 dropped first", {26'b0, en}, 6'h0F);
    drain();
    check("R8 OFF code", {27'b0, state_code}, 0);

    hold_low = 6'b000100;
    push_on_walk();
    pulse(1, 0, 0, 0);
    while (en !== 6'h07) @(negedge clk);
    repeat (5 * T) @(negedge clk);
    check("R4 slot stretched", {26'b0, en}, 6'h07);
    check("R4 walking code", {27'b0, state_code}, 5'b00110);
    hold_low = '0;
    drain();

    pulse(1, 0, 0, 1);
    repeat (20) @(negedge clk);
    check("R11 ignored en", {26'b0, en}, 6'h3F);
    check("R11 ignored code", {27'b0, state_code}, 5'b11111);

    push_sleep_walk();
    pulse(0, 0, 1, 0);
    drain();
    check("R6 masked off", {26'b0, en}, 6'h19);
    check("R8 SLEEP code", {27'b0, state_code}, 5'b11100);

    push_en(6'h1B); push_en(6'h1F); push_en(6'h3F); push_irq(3'b100);
    push_off_walk();
    pulse(0, 0, 0, 1);
    while (en !== 6'h1B) @(negedge clk);
    pulse(0, 1, 1, 0);
    drain();
    check("R10 held OFF won", {27'b0, state_code}, 0);

    push_on_walk();
    pulse(1, 0, 0, 0);
    drain();
    push_sleep_walk();
    pulse(0, 0, 1, 0);
    drain();
    push_en(6'h00); push_irq(3'b010);
    pulse(0, 1, 0, 0);
    check("R7 en cleared next edge", {26'b0, en}, 0);
    check("R7 code OFF", {27'b0, state_code}, 0);
    check("R7 irq_off", {31'b0, irq_off}, 1);
    drain();
    check("R2 scoreboard empty", q.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule